// File: doc/BRIEF.md
# Decode-Stage Branch Resolution and PC Control

This block produces the fetch address of a five-stage pipeline and settles conditional branches and jumps while they sit in the decode stage. A dedicated equality comparator looks at the two operands read for the decode-stage instruction. If the instruction is a jump, or a branch whose condition holds, the next fetch address becomes the supplied target in the same cycle. Because the decision falls in decode, only one sequentially fetched instruction can follow a redirect.

A policy input chooses what happens to that one instruction. Under the delay-slot policy it always proceeds down the pipe, for branches and for jumps alike. Under the predict-not-taken policy fetch keeps running sequentially, and a taken redirect clears the fetch/decode register so that the instruction turns into a bubble. The block also holds the PC of the fetch, decode and execute stages, each with a valid bit, so that the effect of each policy can be observed at its ports. A stall input freezes fetch and decode.

Top module: `br_pc_ctrl`

## Requirements
- R1: While rst_ni is low, pc_o equals RESET_PC, id_vld_o and ex_vld_o are 0, and flush_o is 0.
- R2: With no redirect and no stall, npc_o equals pc_o + 4, and pc_o takes that value at the next edge, while decode and execute shift forward by one stage.
- R3: A decode-stage instruction with id_branch_i=1 and id_br_ne_i=0 is taken exactly when id_opa_i equals id_opb_i. With id_br_ne_i=1 it is taken exactly when they differ. A taken branch drives npc_o to id_target_i in the same cycle.
- R4: id_jump_i=1 redirects npc_o to id_target_i unconditionally, and overrides the branch inputs.
- R5: With mode_i=0 (predict-not-taken), a taken branch or jump raises flush_o in its decode cycle. In the next cycle id_vld_o is 0, and one cycle later ex_vld_o is 0 (a bubble in execute).
- R6: With mode_i=1 (delay slot), flush_o is never raised. The instruction fetched right after a taken branch or jump reaches execute valid, with its PC equal to the branch PC + 4.
- R7: A branch that is not taken never raises flush_o, under either policy.
- R8: While stall_i is 1, npc_o equals pc_o, flush_o is 0, pc_o and the decode stage hold, and execute receives a bubble. A branch held in decode takes effect in the first cycle after the stall ends.
- R9: When id_vld_o is 0, the branch and jump inputs have no effect: npc_o is pc_o + 4 and flush_o is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| mode_i | input | 1 | Policy select: 1 delay slot, 0 predict-not-taken |
| stall_i | input | 1 | Freeze fetch and decode for this cycle |
| id_branch_i | input | 1 | Decode-stage instruction is a conditional branch |
| id_br_ne_i | input | 1 | Branch condition: 0 equal, 1 not equal |
| id_jump_i | input | 1 | Decode-stage instruction is an unconditional jump |
| id_opa_i | input | XLEN | First compared operand |
| id_opb_i | input | XLEN | Second compared operand |
| id_target_i | input | PC_W | Redirect target |
| pc_o | output | PC_W | Current fetch PC |
| npc_o | output | PC_W | Fetch PC for the next cycle |
| flush_o | output | 1 | Clears the fetch/decode register |
| id_pc_o | output | PC_W | PC of the decode-stage instruction |
| id_vld_o | output | 1 | Decode stage holds a live instruction |
| ex_pc_o | output | PC_W | PC of the execute-stage instruction |
| ex_vld_o | output | 1 | Execute stage holds a live instruction |

## Verification
A stall and a taken branch in decode can land in the same cycle. The stall must win: the redirect and the flush are held back, and the branch then resolves in the first cycle after the stall ends. The bench holds a taken equal-branch in decode under predict-not-taken while it raises stall_i. It checks that npc_o stays at pc_o, that flush_o stays low, that the fetch and decode PCs hold and that execute receives a bubble. Then it drops the stall and expects the redirect together with the flush in that same cycle.

// File: rtl/br_pkg.sv
package br_pkg;

  typedef enum logic {
    POL_PNT   = 1'b0,
    POL_DELAY = 1'b1
  } br_policy_e;

  typedef enum logic [1:0] {
    CF_NONE = 2'd0,
    CF_BEQ  = 2'd1,
    CF_BNE  = 2'd2,
    CF_JMP  = 2'd3
  } cf_kind_e;

  // jump dominates branch flags
  function automatic cf_kind_e cf_classify(input logic br, input logic ne, input logic jmp);
    if (jmp)      return CF_JMP;
    else if (br)  return ne ? CF_BNE : CF_BEQ;
    else          return CF_NONE;
  endfunction

endpackage

// File: rtl/br_resolve.sv
module br_resolve
  import br_pkg::*;
#(
  parameter int unsigned XLEN  = 32,
  parameter int unsigned LANES = 4
) (
  input  logic            vld_i,
  input  cf_kind_e        kind_i,
  input  logic [XLEN-1:0] opa_i,
  input  logic [XLEN-1:0] opb_i,
  output logic            taken_o
);
  localparam int unsigned LANE_W = XLEN / LANES;

  logic [LANES-1:0] lane_eq;
  logic             ops_eq;

  // split comparator: per-lane equality, then AND tree
  for (genvar g = 0; g < LANES; g++) begin : g_lane
    assign lane_eq[g] = (opa_i[g*LANE_W +: LANE_W] == opb_i[g*LANE_W +: LANE_W]);
  end

  assign ops_eq = &lane_eq;

  always_comb begin
    unique case (kind_i)
      CF_JMP:  taken_o = vld_i;
      CF_BEQ:  taken_o = vld_i &  ops_eq;
      CF_BNE:  taken_o = vld_i & ~ops_eq;
      default: taken_o = 1'b0;
    endcase
  end
endmodule

// File: rtl/br_npc.sv
module br_npc #(
  parameter int unsigned PC_W = 32,
  parameter int unsigned STEP = 4
) (
  input  logic [PC_W-1:0] pc_i,
  input  logic            taken_i,
  input  logic            stall_i,
  input  logic [PC_W-1:0] target_i,
  output logic [PC_W-1:0] npc_o
);
  localparam logic [PC_W-1:0] STEP_V = PC_W'(STEP);

  always_comb begin
    if (stall_i)      npc_o = pc_i;
    else if (taken_i) npc_o = target_i;
    else              npc_o = pc_i + STEP_V;
  end
endmodule

// File: rtl/br_stage_regs.sv
module br_stage_regs #(
  parameter int unsigned      PC_W     = 32,
  parameter logic [PC_W-1:0]  RESET_PC = '0
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            stall_i,
  input  logic            flush_i,
  input  logic [PC_W-1:0] npc_i,
  output logic [PC_W-1:0] pc_o,
  output logic [PC_W-1:0] id_pc_o,
  output logic            id_vld_o,
  output logic [PC_W-1:0] ex_pc_o,
  output logic            ex_vld_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pc_o     <= RESET_PC;
      id_pc_o  <= RESET_PC;
      id_vld_o <= 1'b0;
      ex_pc_o  <= RESET_PC;
      ex_vld_o <= 1'b0;
    end else begin
      ex_pc_o <= id_pc_o;
      if (stall_i) begin
        ex_vld_o <= 1'b0;  // bubble into execute
      end else begin
        pc_o     <= npc_i;
        id_pc_o  <= pc_o;
        id_vld_o <= ~flush_i;
        ex_vld_o <= id_vld_o;
      end
    end
  end
endmodule

// File: rtl/br_pc_ctrl.sv
module br_pc_ctrl
  import br_pkg::*;
#(
  parameter int unsigned     XLEN     = 32,
  parameter int unsigned     PC_W     = 32,
  parameter int unsigned     PC_STEP  = 4,
  parameter int unsigned     CMP_LANES = 4,
  parameter logic [PC_W-1:0] RESET_PC = '0
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            mode_i,
  input  logic            stall_i,
  input  logic            id_branch_i,
  input  logic            id_br_ne_i,
  input  logic            id_jump_i,
  input  logic [XLEN-1:0] id_opa_i,
  input  logic [XLEN-1:0] id_opb_i,
  input  logic [PC_W-1:0] id_target_i,
  output logic [PC_W-1:0] pc_o,
  output logic [PC_W-1:0] npc_o,
  output logic            flush_o,
  output logic [PC_W-1:0] id_pc_o,
  output logic            id_vld_o,
  output logic [PC_W-1:0] ex_pc_o,
  output logic            ex_vld_o
);
  cf_kind_e   kind;
  br_policy_e policy;
  logic       taken;

  assign kind   = cf_classify(id_branch_i, id_br_ne_i, id_jump_i);
  assign policy = br_policy_e'(mode_i);

  br_resolve #(.XLEN(XLEN), .LANES(CMP_LANES)) u_resolve (
    .vld_i   (id_vld_o),
    .kind_i  (kind),
    .opa_i   (id_opa_i),
    .opb_i   (id_opb_i),
    .taken_o (taken)
  );

  br_npc #(.PC_W(PC_W), .STEP(PC_STEP)) u_npc (
    .pc_i     (pc_o),
    .taken_i  (taken),
    .stall_i  (stall_i),
    .target_i (id_target_i),
    .npc_o    (npc_o)
  );

  assign flush_o = taken & ~stall_i & (policy == POL_PNT);

  br_stage_regs #(.PC_W(PC_W), .RESET_PC(RESET_PC)) u_regs (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .stall_i  (stall_i),
    .flush_i  (flush_o),
    .npc_i    (npc_o),
    .pc_o     (pc_o),
    .id_pc_o  (id_pc_o),
    .id_vld_o (id_vld_o),
    .ex_pc_o  (ex_pc_o),
    .ex_vld_o (ex_vld_o)
  );
endmodule

// File: rtl/br_pc_ctrl_chk.sv
module br_pc_ctrl_chk #(
  parameter int unsigned PC_W = 32,
  parameter int unsigned STEP = 4
) (
  input logic            clk_i,
  input logic            rst_ni,
  input logic            mode_i,
  input logic            stall_i,
  input logic            id_branch_i,
  input logic            id_jump_i,
  input logic [PC_W-1:0] pc_o,
  input logic [PC_W-1:0] npc_o,
  input logic            flush_o,
  input logic [PC_W-1:0] id_pc_o,
  input logic            id_vld_o,
  input logic [PC_W-1:0] ex_pc_o,
  input logic            ex_vld_o
);
  localparam logic [PC_W-1:0] STEP_V = PC_W'(STEP);

  // R2
  seq_adv_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!stall_i && !(id_vld_o && (id_branch_i || id_jump_i))) |=> pc_o == $past(pc_o) + STEP_V);

  // R5
  flush_bubble_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flush_o |=> !id_vld_o);

  // R6
  delay_no_flush_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mode_i |-> !flush_o);

  // R8
  stall_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stall_i |-> (!flush_o && npc_o == pc_o));

  // R8
  stall_freeze_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stall_i |=> (pc_o == $past(pc_o) && id_pc_o == $past(id_pc_o) && !ex_vld_o));

  // R9
  dead_slot_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!id_vld_o && !stall_i) |-> (!flush_o && npc_o == pc_o + STEP_V));

  // R2
  ex_shift_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !stall_i |=> (ex_pc_o == $past(id_pc_o) && ex_vld_o == $past(id_vld_o)));
endmodule

bind br_pc_ctrl br_pc_ctrl_chk #(.PC_W(PC_W), .STEP(PC_STEP)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .mode_i      (mode_i),
  .stall_i     (stall_i),
  .id_branch_i (id_branch_i),
  .id_jump_i   (id_jump_i),
  .pc_o        (pc_o),
  .npc_o       (npc_o),
  .flush_o     (flush_o),
  .id_pc_o     (id_pc_o),
  .id_vld_o    (id_vld_o),
  .ex_pc_o     (ex_pc_o),
  .ex_vld_o    (ex_vld_o)
);

// File: tb/br_pc_ctrl_tb.sv
`timescale 1ns/1ps
module br_pc_ctrl_tb;
  localparam logic [31:0] RST_PC = 32'h0000_0400;

  logic        clk = 1'b0;
  logic        rst_ni;
  logic        mode, stall, br, ne, jmp;
  logic [31:0] opa, opb, tgt;
  logic [31:0] pc, npc, id_pc, ex_pc;
  logic        flush, id_vld, ex_vld;

  int n_run  = 0;
  int n_fail = 0;
  bit done   = 1'b0;

  always #2.5 clk = ~clk;

  br_pc_ctrl #(.RESET_PC(RST_PC)) u_dut (
    .clk_i(clk), .rst_ni(rst_ni), .mode_i(mode), .stall_i(stall),
    .id_branch_i(br), .id_br_ne_i(ne), .id_jump_i(jmp),
    .id_opa_i(opa), .id_opb_i(opb), .id_target_i(tgt),
    .pc_o(pc), .npc_o(npc), .flush_o(flush),
    .id_pc_o(id_pc), .id_vld_o(id_vld), .ex_pc_o(ex_pc), .ex_vld_o(ex_vld)
  );

  // kind: 0 none, 1 beq, 2 bne, 3 jump
  typedef struct packed {
    logic        mode;
    logic [1:0]  kind;
    logic [31:0] a;
    logic [31:0] b;
    logic [31:0] t;
    logic        taken;
  } vec_t;

  localparam vec_t VECS [10] = '{
    '{1'b1, 2'd1, 32'h0000_0055, 32'h0000_0055, 32'h0000_2000, 1'b1},
    '{1'b1, 2'd1, 32'h0000_0055, 32'h8000_0055, 32'h0000_3000, 1'b0},
    '{1'b1, 2'd2, 32'h1234_0000, 32'h1234_0001, 32'h0000_4000, 1'b1},
    '{1'b1, 2'd3, 32'h0000_0001, 32'h0000_0002, 32'h0000_5000, 1'b1},
    '{1'b0, 2'd1, 32'hdead_beef, 32'hdead_beef, 32'h0000_6000, 1'b1},
    '{1'b0, 2'd1, 32'hdead_beef, 32'hdeaf_beef, 32'h0000_7000, 1'b0},
    '{1'b0, 2'd2, 32'hffff_ffff, 32'hffff_ffff, 32'h0000_8000, 1'b0},
    '{1'b0, 2'd2, 32'h0000_0000, 32'h0001_0000, 32'h0000_9000, 1'b1},
    '{1'b0, 2'd3, 32'h0000_0003, 32'h0000_0003, 32'h0000_a000, 1'b1},
    '{1'b1, 2'd2, 32'h0000_0007, 32'h0000_0007, 32'h0000_b000, 1'b0}
  };

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic idle_inputs();
    br = 1'b0; ne = 1'b0; jmp = 1'b0; stall = 1'b0;
    opa = '0; opb = '0; tgt = '0;
  endtask

  task automatic run_vec(input vec_t v);
    logic [31:0] bpc, slot, exp_npc;
    logic        exp_flush;
    string       rtag, ftag;
    @(negedge clk);
    mode = v.mode;
    bpc  = id_pc;
    slot = pc;
    chk(id_vld == 1'b1 && slot == bpc + 32'd4, "R2", slot, bpc + 32'd4);
    br  = (v.kind == 2'd1 || v.kind == 2'd2);
    ne  = (v.kind == 2'd2);
    jmp = (v.kind == 2'd3);
    opa = v.a; opb = v.b; tgt = v.t;
    exp_npc   = v.taken ? v.t : slot + 32'd4;
    exp_flush = v.taken && !v.mode;
    rtag = (v.kind == 2'd3) ? "R4" : "R3";
    ftag = !v.taken ? "R7" : (v.mode ? "R6" : "R5");
    #1;
    chk(npc == exp_npc, rtag, npc, exp_npc);
    chk(flush == exp_flush, ftag, {31'd0, flush}, {31'd0, exp_flush});
    @(negedge clk);
    idle_inputs();
    chk(pc == exp_npc, rtag, pc, exp_npc);
    chk(id_pc == slot && id_vld == !exp_flush, ftag, {31'd0, id_vld}, {31'd0, !exp_flush});
    chk(ex_pc == bpc && ex_vld, "R2", ex_pc, bpc);
    @(negedge clk);
    // slot instruction in execute: live in delay mode, bubble after a flush
    chk(ex_pc == slot, ftag, ex_pc, slot);
    chk(ex_vld == !exp_flush, ftag, {31'd0, ex_vld}, {31'd0, !exp_flush});
  endtask

  initial begin
    #1_000_000;
    if (!done) begin
      n_run++;
      n_fail++;
      $display("FAIL watchdog: actual %h expected %h", 32'd0, 32'd1);
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    logic [31:0] hold_pc, hold_id;
    rst_ni = 1'b0;
    mode   = 1'b0;
    idle_inputs();
    #12;
    // R1 reset state
    chk(pc == RST_PC, "R1", pc, RST_PC);
    chk(!id_vld && !ex_vld, "R1", {30'd0, id_vld, ex_vld}, 32'd0);
    chk(!flush, "R1", {31'd0, flush}, 32'd0);

    @(negedge clk);
    rst_ni = 1'b1;
    // R9: decode empty, jump request must be ignored
    jmp = 1'b1; tgt = 32'h0000_0900;
    #1;
    chk(npc == RST_PC + 32'd4, "R9", npc, RST_PC + 32'd4);
    chk(!flush, "R9", {31'd0, flush}, 32'd0);
    @(negedge clk);
    idle_inputs();
    chk(pc == RST_PC + 32'd4, "R9", pc, RST_PC + 32'd4);
    chk(id_vld && id_pc == RST_PC, "R2", id_pc, RST_PC);
    @(negedge clk);
    chk(pc == RST_PC + 32'd8, "R2", pc, RST_PC + 32'd8);
    chk(npc == RST_PC + 32'd12, "R2", npc, RST_PC + 32'd12);

    for (int i = 0; i < 10; i++) run_vec(VECS[i]);

    // R8: stall coincides with a taken branch in decode
    @(negedge clk);
    mode = 1'b0;
    hold_pc = pc;
    hold_id = id_pc;
    br = 1'b1; ne = 1'b0; opa = 32'h11; opb = 32'h11; tgt = 32'h0000_c000;
    stall = 1'b1;
    #1;
    chk(npc == hold_pc, "R8", npc, hold_pc);
    chk(!flush, "R8", {31'd0, flush}, 32'd0);
    @(negedge clk);
    chk(pc == hold_pc && id_pc == hold_id, "R8", pc, hold_pc);
    chk(!ex_vld && id_vld, "R8", {31'd0, ex_vld}, 32'd0);
    stall = 1'b0;
    #1;
    chk(npc == 32'h0000_c000, "R8", npc, 32'h0000_c000);
    chk(flush, "R8", {31'd0, flush}, 32'd1);
    @(negedge clk);
    idle_inputs();
    chk(pc == 32'h0000_c000, "R8", pc, 32'h0000_c000);
    chk(!id_vld, "R5", {31'd0, id_vld}, 32'd0);
    @(negedge clk);
    chk(!ex_vld && id_vld && id_pc == 32'h0000_c000, "R5", id_pc, 32'h0000_c000);

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule